// File: doc/BRIEF.md
# Bank Select Port

This block is a write-only, I/O-mapped register that holds the number of the memory bank currently switched into a 16-bit address space. The processor selects a bank by performing an I/O write to the port. The low six data bits become the new bank number, which drives the memory decoder directly. Every memory board in a system sees the same writes, so all of them track the same bank.

Three static configuration inputs set up the port. The first picks its address anywhere in the 256-location I/O space; the usual setting is 8'hEE. The second chooses how the expansion qualifier line is used. The third can switch the port off completely. Reset, and a disabled port, both leave bank 0 selected.

The block is synchronous to `clk_i`. A write is recognised on the first clock at which the write strobe is seen high after having been low. The address, request, qualifier and data inputs are sampled at that same clock.

Top module: `bank_port`

## Requirements
- R1: While `rst_ni` is low, `bank_o` is 0, without waiting for a clock edge.
- R2: A write hits the port when all of these hold at a clock edge: `io_wr_i` is high and was low at the previous edge, `io_req_i` is high, `io_addr_i` equals `cfg_addr_i`, the qualifier check passes, and `cfg_en_i` is high. On a hit, `bank_o` shows `io_data_i[5:0]` from that edge onward.
- R3: `io_data_i[7:6]` have no effect on the stored bank.
- R4: While `io_wr_i` stays high over several edges, only the first edge can load. Changes to the data or address during the rest of the strobe leave `bank_o` unchanged.
- R5: A write with `io_req_i` low, or with `io_addr_i` different from `cfg_addr_i`, leaves `bank_o` unchanged.
- R6: `cfg_exp_mode_i` selects the qualifier check. 2'b01 requires `exp_i` high. 2'b10 requires `exp_i` low. 2'b00 and 2'b11 ignore `exp_i`.
- R7: The port responds at every address from 8'h00 to 8'hFF, including both ends and 8'hEE.
- R8: Every bank number from 6'h00 to 6'h3F can be stored and read back.
- R9: While `cfg_en_i` is low, writes are ignored, and `bank_o` becomes 0 at the next clock edge and stays 0.
- R10: Apart from R1, R2 and R9, `bank_o` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | Low byte of the I/O address |
| io_data_i | input | 8 | Data bus |
| io_wr_i | input | 1 | I/O write strobe, active high |
| io_req_i | input | 1 | I/O cycle request, active high |
| exp_i | input | 1 | Expansion qualifier line |
| cfg_addr_i | input | 8 | Port address setting |
| cfg_exp_mode_i | input | 2 | Qualifier mode (01 high, 10 low, 00/11 ignore) |
| cfg_en_i | input | 1 | Port enable |
| bank_o | output | 6 | Selected bank number |

## Verification
The hardest case to reach is a held strobe. The write line stays high over several edges while the data and address move to values that would be a hit if the strobe were fresh. Only the edge detector keeps these from loading. The stimulus holds `io_wr_i` high across several driver steps and changes the data under it, and the bench expects the first value to remain. A second hard case disables the port after a nonzero bank has been loaded and then issues matching writes. The clear and the ignored writes are both visible on `bank_o`.

// File: rtl/bank_port_pkg.sv
package bank_port_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BANK_W = 6;

  typedef enum logic [1:0] {
    EXP_ANY  = 2'b00,
    EXP_HIGH = 2'b01,
    EXP_LOW  = 2'b10,
    EXP_ANY2 = 2'b11
  } exp_mode_e;
endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode
  import bank_port_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] io_addr_i,
  input  logic          io_req_i,
  input  logic          exp_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  exp_mode_e     cfg_exp_mode_i,
  input  logic          cfg_en_i,
  output logic          sel_o
);
  logic addr_hit;
  logic exp_ok;

  assign addr_hit = (io_addr_i == cfg_addr_i);

  always_comb begin
    unique case (cfg_exp_mode_i)
      EXP_HIGH: exp_ok = exp_i;
      EXP_LOW:  exp_ok = !exp_i;
      default:  exp_ok = 1'b1;
    endcase
  end

  assign sel_o = cfg_en_i && io_req_i && addr_hit && exp_ok;

  assert_exp_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && cfg_exp_mode_i == EXP_HIGH) |-> exp_i);
  assert_exp_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && cfg_exp_mode_i == EXP_LOW) |-> !exp_i);
endmodule

// File: rtl/bank_port_strobe.sv
module bank_port_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic rise_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  assign rise_o = wr_i && !wr_q;

  // a held strobe yields one event only
  assert_single_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bank_port_reg.sv
module bank_port_reg
  import bank_port_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BANK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [BW-1:0] bank_o
);
  logic [BW-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bank_q <= '0;
    else if (clear_i) bank_q <= '0;
    else if (load_i)  bank_q <= data_i[BW-1:0];
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/bank_port.sv
module bank_port
  import bank_port_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BANK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] io_addr_i,
  input  logic [DW-1:0] io_data_i,
  input  logic          io_wr_i,
  input  logic          io_req_i,
  input  logic          exp_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [1:0]    cfg_exp_mode_i,
  input  logic          cfg_en_i,
  output logic [BW-1:0] bank_o
);
  logic sel;
  logic wr_rise;
  logic load;

  bank_port_decode #(.AW(AW)) u_decode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .io_addr_i      (io_addr_i),
    .io_req_i       (io_req_i),
    .exp_i          (exp_i),
    .cfg_addr_i     (cfg_addr_i),
    .cfg_exp_mode_i (exp_mode_e'(cfg_exp_mode_i)),
    .cfg_en_i       (cfg_en_i),
    .sel_o          (sel)
  );

  bank_port_strobe u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (io_wr_i),
    .rise_o (wr_rise)
  );

  assign load = sel && wr_rise;

  bank_port_reg #(.DW(DW), .BW(BW)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!cfg_en_i),
    .load_i  (load),
    .data_i  (io_data_i),
    .bank_o  (bank_o)
  );

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && wr_rise) |=> bank_o == $past(io_data_i[BW-1:0]));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !(sel && wr_rise)) |=> $stable(bank_o));
  assert_disable_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> bank_o == '0);
  assert_no_sel_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |-> !sel);
endmodule

// File: tb/bank_port_tb_top.sv
module bank_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_data = '0;
  logic       io_wr = 1'b0;
  logic       io_req = 1'b0;
  logic       exp_l = 1'b0;
  logic [7:0] cfg_addr = 8'hEE;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_en = 1'b1;
  logic [5:0] bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] model = '0;
  logic       prev_wr = 1'b0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  bank_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .io_addr_i(io_addr), .io_data_i(io_data),
    .io_wr_i(io_wr), .io_req_i(io_req), .exp_i(exp_l), .cfg_addr_i(cfg_addr),
    .cfg_exp_mode_i(cfg_mode), .cfg_en_i(cfg_en), .bank_o(bank)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // driver: called at a negedge, sets inputs, pushes expectation, waits next negedge
  task automatic drive(input string tag, input logic [7:0] a, input logic [7:0] d,
                       input logic wr, input logic req, input logic e);
    logic ok;
    io_addr = a; io_data = d; io_wr = wr; io_req = req; exp_l = e;
    case (cfg_mode)
      2'b01:   ok = e;
      2'b10:   ok = !e;
      default: ok = 1'b1;
    endcase
    if (!cfg_en) model = '0;
    else if (wr && !prev_wr && req && a == cfg_addr && ok) model = d[5:0];
    prev_wr = wr;
    exp_q.push_back(model);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr_pulse(input string tag, input logic [7:0] a, input logic [7:0] d,
                          input logic req, input logic e);
    drive(tag, a, d, 1'b1, req, e);
    drive(tag, a, d, 1'b0, req, e);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check(tag_q.pop_front(), bank, exp_q.pop_front());
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", bank, 6'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 basic write at default port, R3 top bits ignored
    wr_pulse("R2 write", 8'hEE, 8'h05, 1'b1, 1'b0);
    wr_pulse("R3 d7d6", 8'hEE, 8'hC9, 1'b1, 1'b0);
    // R5 mismatch and no request
    wr_pulse("R5 addr", 8'hED, 8'h11, 1'b1, 1'b0);
    wr_pulse("R5 req", 8'hEE, 8'h12, 1'b0, 1'b0);
    // R4 held strobe with moving data
    drive("R4 first", 8'hEE, 8'h21, 1'b1, 1'b1, 1'b0);
    drive("R4 held", 8'hEE, 8'h22, 1'b1, 1'b1, 1'b0);
    drive("R4 held", 8'hEE, 8'h23, 1'b1, 1'b1, 1'b0);
    drive("R4 end", 8'hEE, 8'h24, 1'b0, 1'b1, 1'b0);
    // R10 idle cycles
    drive("R10 idle", 8'hEE, 8'h3F, 1'b0, 1'b1, 1'b0);
    drive("R10 idle", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);

    // R6 qualifier modes
    cfg_mode = 2'b01;
    wr_pulse("R6 high miss", 8'hEE, 8'h31, 1'b1, 1'b0);
    wr_pulse("R6 high hit", 8'hEE, 8'h32, 1'b1, 1'b1);
    cfg_mode = 2'b10;
    wr_pulse("R6 low miss", 8'hEE, 8'h33, 1'b1, 1'b1);
    wr_pulse("R6 low hit", 8'hEE, 8'h34, 1'b1, 1'b0);
    cfg_mode = 2'b11;
    wr_pulse("R6 any hi", 8'hEE, 8'h35, 1'b1, 1'b1);
    wr_pulse("R6 any lo", 8'hEE, 8'h36, 1'b1, 1'b0);
    cfg_mode = 2'b00;
    wr_pulse("R6 any0", 8'hEE, 8'h37, 1'b1, 1'b1);

    // R7 address boundaries
    cfg_addr = 8'h00;
    wr_pulse("R7 addr00", 8'h00, 8'h0A, 1'b1, 1'b0);
    wr_pulse("R7 miss01", 8'h01, 8'h0B, 1'b1, 1'b0);
    cfg_addr = 8'hFF;
    wr_pulse("R7 addrFF", 8'hFF, 8'h0C, 1'b1, 1'b0);
    wr_pulse("R7 missFE", 8'hFE, 8'h0D, 1'b1, 1'b0);

    // R8 every bank value
    for (int v = 0; v < 64; v++)
      wr_pulse("R8 sweep", 8'hFF, 8'(v), 1'b1, 1'b0);

    // R9 disable clears and ignores writes
    wr_pulse("R9 preload", 8'hFF, 8'h2A, 1'b1, 1'b0);
    cfg_en = 1'b0;
    drive("R9 clear", 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
    wr_pulse("R9 ignored", 8'hFF, 8'h15, 1'b1, 1'b0);
    cfg_mode = 2'b01;
    wr_pulse("R9 ignored", 8'hFF, 8'h16, 1'b1, 1'b1);
    cfg_en = 1'b1;
    cfg_mode = 2'b00;
    wr_pulse("R9 reenable", 8'hFF, 8'h17, 1'b1, 1'b0);

    // R1 reset in the middle of a run
    drive("R10 idle", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    #1;
    check("R1 async", bank, 6'h00);
    model = '0;
    prev_wr = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive("R1 after", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    wr_pulse("R2 after rst", 8'hFF, 8'h3E, 1'b1, 1'b0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule